// File: doc/BRIEF.md
# Committed-Ratio Clock Enable Divider Bank

This block produces eleven clock-enable strobes from a single fast source clock. Each strobe channel divides the source by a ratio chosen from a fixed table of fourteen irregular values (2, 3, 4, 6, 8, 12, 16, 18, 24, 32, 36, 48, 72, 96). Software selects each ratio through a 4-bit code held in one of three 32-bit setting words. A fourth word holds a per-channel run mask.

Code writes go to a pending copy only. A channel picks up its pending code when software sets the commit bit. It does so at its own next period boundary, so no channel ever emits a shortened or stretched period. The commit bit reads back as 1 until every channel has loaded, then clears itself. A write carrying a reserved code leaves that field untouched and raises a sticky error flag.

Top module: `cdiv_bank`

## Requirements
- R1: After reset every field reads code 0 (ratio 2), the commit bit (word 1 bit 31) and error flag (word 1 bit 0) read 0, and the run word (address 3) reads 0x00F. Channels 0 to 3 strobe every 2 cycles and the others stay silent.
- R2: Codes 0 to 15 map to the ratios 2, 3, 4, 6, 8, 12, 16, 18, 24, 32, 36, 48, reserved, 72, 96, reserved. A running channel's strobe repeats every ratio source cycles.
- R3: Channel fields sit at these places: channels 0 to 3 in word 0 at bits 23:20, 19:16, 11:8 and 7:4; channel 4 in word 1 at bits 7:4; channels 5 to 10 in word 2 at bits 23:20, 19:16, 15:12, 11:8, 7:4 and 3:0. Each field reads back its pending code.
- R4: A field write without a commit leaves the channel's running ratio unchanged.
- R5: Writing 1 to word 1 bit 31 starts a commit. The bit reads 1 until every channel has loaded its pending code, then reads 0 by itself.
- R6: A running channel loads its new ratio at the edge of its next strobe. The old period completes in full, and the new period is counted from that edge.
- R7: A write carrying code 12 or 15 in a field leaves that field at its previous value, while valid fields in the same write still update. It also sets the error flag.
- R8: The error flag stays set until a write to word 1 with bit 0 set clears it.
- R9: Bits 10:0 of address 3 are the run mask. A channel with its bit at 0 never strobes and restarts its count from zero when run again. A stopped channel loads a committed code on the next cycle.
- R10: Each strobe is high for exactly one source cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Source clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe for one word |
| wr_addr | input | 2 | Word select: 0, 1, 2 settings, 3 run mask |
| wr_data | input | 32 | Write data |
| rd_addr | input | 2 | Read word select |
| rd_data | output | 32 | Combinational read data |
| tick | output | 11 | One enable strobe per channel |

## Verification
The bench aims at the boundary commit. A slow channel at ratio 96 is committed to ratio 3 just after one of its strobes. A design that loaded the code at once would strobe early instead of after the full 96 cycles, and one that cleared the commit bit early would read 0 while the load is still pending. Reserved codes are written next to valid ones in the same word. A design that rejected the whole word, or stored the reserved code, shows a wrong readback. A stopped channel is committed while idle. A design waiting for that channel's boundary would never clear the commit bit.

// File: rtl/cdiv_pkg.sv
package cdiv_pkg;
  localparam int NCH = 11;
  localparam int CODE_W = 4;
  localparam int CNT_W = 7;
  localparam logic [15:0] CODE_OK_MASK = 16'h6FFF;
  localparam logic [1:0] ADDR_A = 2'd0;
  localparam logic [1:0] ADDR_B = 2'd1;
  localparam logic [1:0] ADDR_C = 2'd2;
  localparam logic [1:0] ADDR_RUN = 2'd3;
  localparam int COMMIT_BIT = 31;
  localparam int ERR_BIT = 0;

  typedef logic [NCH-1:0][CODE_W-1:0] code_vec_t;

  function automatic logic code_ok(input logic [CODE_W-1:0] c);
    return CODE_OK_MASK[c];
  endfunction

  function automatic logic [CNT_W-1:0] ratio_of(input logic [CODE_W-1:0] c);
    case (c)
      4'd0:  return CNT_W'(2);
      4'd1:  return CNT_W'(3);
      4'd2:  return CNT_W'(4);
      4'd3:  return CNT_W'(6);
      4'd4:  return CNT_W'(8);
      4'd5:  return CNT_W'(12);
      4'd6:  return CNT_W'(16);
      4'd7:  return CNT_W'(18);
      4'd8:  return CNT_W'(24);
      4'd9:  return CNT_W'(32);
      4'd10: return CNT_W'(36);
      4'd11: return CNT_W'(48);
      4'd13: return CNT_W'(72);
      4'd14: return CNT_W'(96);
      default: return CNT_W'(2);
    endcase
  endfunction

  function automatic logic [1:0] chan_word(input int i);
    if (i < 4) return ADDR_A;
    else if (i == 4) return ADDR_B;
    else return ADDR_C;
  endfunction

  function automatic int chan_off(input int i);
    case (i)
      0: return 20;
      1: return 16;
      2: return 8;
      3: return 4;
      4: return 4;
      5: return 20;
      6: return 16;
      7: return 12;
      8: return 8;
      9: return 4;
      default: return 0;
    endcase
  endfunction
endpackage

// File: rtl/cdiv_regs.sv
module cdiv_regs
  import cdiv_pkg::*;
#(
  parameter logic [NCH-1:0] RUN_RST = 'h00F
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_en,
  input  logic [1:0]      wr_addr,
  input  logic [31:0]     wr_data,
  input  logic [1:0]      rd_addr,
  input  logic [NCH-1:0]  ld_ack,
  output logic [31:0]     rd_data,
  output code_vec_t       pend,
  output logic [NCH-1:0]  run,
  output logic [NCH-1:0]  ld_req,
  output logic            busy,
  output logic            err,
  output logic            kick,
  output logic            err_clr
);
  logic [NCH-1:0] bad;
  logic           unused_wr;

  assign unused_wr = ^wr_data[30:24];
  assign kick    = wr_en && (wr_addr == ADDR_B) && wr_data[COMMIT_BIT];
  assign err_clr = wr_en && (wr_addr == ADDR_B) && wr_data[ERR_BIT];
  assign busy    = |ld_req;

  for (genvar i = 0; i < NCH; i++) begin : g_field
    localparam int OFF = chan_off(i);
    localparam logic [1:0] WORD = chan_word(i);
    logic hit;
    logic [CODE_W-1:0] nv;
    assign hit = wr_en && (wr_addr == WORD);
    assign nv  = wr_data[OFF +: CODE_W];
    assign bad[i] = hit && !code_ok(nv);
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pend[i] <= '0;
      else if (hit && code_ok(nv)) pend[i] <= nv;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      err    <= 1'b0;
      ld_req <= '0;
      run    <= RUN_RST;
    end else begin
      if (|bad) err <= 1'b1;
      else if (err_clr) err <= 1'b0;
      ld_req <= (ld_req & ~ld_ack) | {NCH{kick}};
      if (wr_en && (wr_addr == ADDR_RUN)) run <= wr_data[NCH-1:0];
    end
  end

  always_comb begin
    rd_data = '0;
    for (int i = 0; i < NCH; i++) begin
      if (chan_word(i) == rd_addr) rd_data[chan_off(i) +: CODE_W] = pend[i];
    end
    if (rd_addr == ADDR_B) begin
      rd_data[COMMIT_BIT] = busy;
      rd_data[ERR_BIT]    = err;
    end
    if (rd_addr == ADDR_RUN) rd_data[NCH-1:0] = run;
  end
endmodule

// File: rtl/cdiv_chan.sv
module cdiv_chan
  import cdiv_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run,
  input  logic [CODE_W-1:0] pend_code,
  input  logic              ld_req,
  output logic              tick,
  output logic              ld_ack,
  output logic [CODE_W-1:0] act_code
);
  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] lim;

  assign lim    = ratio_of(act_code) - CNT_W'(1);
  assign tick   = run && (cnt == lim);
  assign ld_ack = ld_req && (tick || !run);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt      <= '0;
      act_code <= '0;
    end else begin
      if (ld_ack) act_code <= pend_code;
      if (!run || tick) cnt <= '0;
      else cnt <= cnt + CNT_W'(1);
    end
  end
endmodule

// File: rtl/cdiv_bank.sv
module cdiv_bank
  import cdiv_pkg::*;
#(
  parameter logic [NCH-1:0] RUN_RST = 'h00F
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_en,
  input  logic [1:0]      wr_addr,
  input  logic [31:0]     wr_data,
  input  logic [1:0]      rd_addr,
  output logic [31:0]     rd_data,
  output logic [NCH-1:0]  tick
);
  code_vec_t      pend;
  code_vec_t      act;
  logic [NCH-1:0] run;
  logic [NCH-1:0] ld_req;
  logic [NCH-1:0] ld_ack;
  logic           busy;
  logic           err;
  logic           kick;
  logic           err_clr;

  cdiv_regs #(.RUN_RST(RUN_RST)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_addr(rd_addr), .ld_ack(ld_ack),
    .rd_data(rd_data), .pend(pend), .run(run), .ld_req(ld_req),
    .busy(busy), .err(err), .kick(kick), .err_clr(err_clr)
  );

  for (genvar i = 0; i < NCH; i++) begin : g_chan
    cdiv_chan u_chan (
      .clk(clk), .rst_n(rst_n), .run(run[i]), .pend_code(pend[i]),
      .ld_req(ld_req[i]), .tick(tick[i]), .ld_ack(ld_ack[i]),
      .act_code(act[i])
    );
  end
endmodule

// File: rtl/cdiv_bank_chk.sv
module cdiv_bank_chk
  import cdiv_pkg::*;
(
  input logic           clk,
  input logic           rst_n,
  input logic [NCH-1:0] tick,
  input logic [NCH-1:0] run,
  input logic [NCH-1:0] ld_ack,
  input code_vec_t      act,
  input code_vec_t      pend,
  input logic           busy,
  input logic           kick,
  input logic           err,
  input logic           err_clr
);
  function automatic logic all_ok(input code_vec_t v);
    logic ok;
    ok = 1'b1;
    for (int i = 0; i < NCH; i++) ok &= code_ok(v[i]);
    return ok;
  endfunction

  AST_ACT_CODE_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    all_ok(act)); // R2
  AST_PEND_CODE_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    all_ok(pend)); // R7
  AST_ACT_ONLY_ON_ACK: assert property (@(posedge clk) disable iff (!rst_n)
    (act != $past(act)) |-> $past(|ld_ack)); // R4
  AST_BUSY_AFTER_KICK: assert property (@(posedge clk) disable iff (!rst_n)
    kick |=> busy); // R5
  AST_BUSY_FALL_ON_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> $past(|ld_ack)); // R6
  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(err) |-> $past(err_clr)); // R8
  AST_STOPPED_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    (tick & ~run) == '0); // R9
  AST_TICK_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    (tick & $past(tick)) == '0); // R10
endmodule

bind cdiv_bank cdiv_bank_chk u_chk (
  .clk(clk), .rst_n(rst_n), .tick(tick), .run(run), .ld_ack(ld_ack),
  .act(act), .pend(pend), .busy(busy), .kick(kick), .err(err),
  .err_clr(err_clr)
);

// File: tb/cdiv_bank_tb.sv
`timescale 1ns/1ps
module cdiv_bank_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic [1:0]  rd_addr = '0;
  logic [31:0] rd_data;
  logic [10:0] tick;

  int checks = 0;
  int errors = 0;
  int sh [11];
  int ratio_tab [16] = '{2, 3, 4, 6, 8, 12, 16, 18, 24, 32, 36, 48, 0, 72, 96, 0};
  int pos_tab [11] = '{20, 16, 8, 4, 4, 20, 16, 12, 8, 4, 0};
  int word_tab [11] = '{0, 0, 0, 0, 1, 2, 2, 2, 2, 2, 2};

  always #10 clk = ~clk;

  cdiv_bank u_dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data), .tick(tick)
  );

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic [31:0] build(input int w);
    logic [31:0] v = '0;
    for (int i = 0; i < 11; i++)
      if (word_tab[i] == w) v |= 32'(sh[i]) << pos_tab[i];
    return v;
  endfunction

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] d);
    rd_addr = a;
    #1;
    d = rd_data;
  endtask

  task automatic commit();
    wr(2'd1, build(1) | 32'h8000_0000);
  endtask

  task automatic wait_idle();
    logic [31:0] d;
    for (int n = 0; n < 400; n++) begin
      rd(2'd1, d);
      if (!d[31]) return;
      @(negedge clk);
    end
    chk(0, "R5 commit never cleared", 1, 0);
  endtask

  // Waits for a strobe, checks it lasts one cycle, returns cycles to the next one.
  task automatic period(input int ch, output int n);
    int w = 0;
    n = 0;
    while (!tick[ch] && w < 400) begin @(negedge clk); w++; end
    @(negedge clk);
    n = 1;
    chk(tick[ch] == 1'b0, "R10 strobe width", tick[ch], 0);
    while (!tick[ch] && n < 400) begin @(negedge clk); n++; end
  endtask

  task automatic silent(input int ch, input int cyc, input string req);
    int seen = 0;
    for (int k = 0; k < cyc; k++) begin @(negedge clk); if (tick[ch]) seen++; end
    chk(seen == 0, req, seen, 0);
  endtask

  task automatic t_reset();
    logic [31:0] d;
    int n;
    rd(2'd0, d); chk(d == 0, "R1 word0", d, 0);
    rd(2'd1, d); chk(d == 0, "R1 word1", d, 0);
    rd(2'd2, d); chk(d == 0, "R1 word2", d, 0);
    rd(2'd3, d); chk(d == 32'h00F, "R1 run word", d, 15);
    for (int c = 0; c < 4; c++) begin period(c, n); chk(n == 2, "R1 default ratio", n, 2); end
    silent(4, 60, "R1 channel 4 stopped");
  endtask

  task automatic t_nokick();
    int n;
    sh[1] = 5;
    wr(2'd0, build(0));
    period(1, n); chk(n == 2, "R4 no change before commit", n, 2);
    commit(); wait_idle();
    period(1, n); chk(n == 12, "R5 commit applies ratio", n, 12);
  endtask

  task automatic t_table();
    int n;
    for (int c = 0; c < 16; c++) begin
      if (ratio_tab[c] == 0) continue;
      sh[0] = c;
      wr(2'd0, build(0));
      commit(); wait_idle();
      period(0, n);
      chk(n == ratio_tab[c], $sformatf("R2 code %0d", c), n, ratio_tab[c]);
    end
  endtask

  task automatic t_boundary();
    logic [31:0] d;
    int n, m;
    sh[2] = 14;
    wr(2'd0, build(0)); commit(); wait_idle();
    sh[2] = 1;
    wr(2'd0, build(0));
    n = 0;
    while (!tick[2] && n < 400) begin @(negedge clk); n++; end
    commit();
    rd(2'd1, d); chk(d[31] == 1'b1, "R5 commit bit reads 1 while pending", d[31], 1);
    n = 2;
    while (!tick[2] && n < 400) begin @(negedge clk); n++; end
    chk(n == 96, "R6 old period completes", n, 96);
    @(negedge clk);
    rd(2'd1, d); chk(d[31] == 1'b0, "R5 commit self-clears", d[31], 0);
    m = 1;
    while (!tick[2] && m < 400) begin @(negedge clk); m++; end
    chk(m == 3, "R6 new period from boundary", m, 3);
  endtask

  task automatic t_fields();
    logic [31:0] d;
    for (int i = 0; i < 11; i++) sh[i] = (i * 5 + 3) % 12;
    wr(2'd0, build(0)); wr(2'd1, build(1)); wr(2'd2, build(2));
    rd(2'd0, d); chk(d == build(0), "R3 word0 readback", d, build(0));
    rd(2'd1, d); chk(d == build(1), "R3 word1 readback", d, build(1));
    rd(2'd2, d); chk(d == build(2), "R3 word2 readback", d, build(2));
  endtask

  task automatic t_reserved();
    logic [31:0] d;
    logic [31:0] e;
    e = build(0);
    sh[1] = 9;
    wr(2'd0, (build(0) & ~32'h00F0_0000) | 32'h00C0_0000);
    e = build(0);
    rd(2'd0, d); chk(d == e, "R7 code 12 rejected, neighbour stored", d, e);
    rd(2'd1, d); chk(d[0] == 1'b1, "R7 error flag set", d[0], 1);
    sh[4] = 15;
    wr(2'd1, 32'h0000_00F0);
    sh[4] = (4 * 5 + 3) % 12;
    rd(2'd1, d); chk(d[7:4] == 4'(sh[4]), "R7 code 15 rejected", d[7:4], sh[4]);
    wr(2'd0, build(0));
    rd(2'd1, d); chk(d[0] == 1'b1, "R8 flag survives good write", d[0], 1);
    wr(2'd1, build(1) | 32'h1);
    rd(2'd1, d); chk(d[0] == 1'b0, "R8 flag cleared", d[0], 0);
  endtask

  task automatic t_run();
    int n;
    sh[5] = 3; sh[6] = 2;
    wr(2'd2, build(2));
    wr(2'd3, 32'h00F);
    commit(); wait_idle();
    wr(2'd3, 32'h06F);
    period(5, n); chk(n == 6, "R9 run channel 5", n, 6);
    period(6, n); chk(n == 4, "R9 stopped channel loaded", n, 4);
    wr(2'd3, 32'h04F);
    silent(5, 100, "R9 channel 5 stopped");
  endtask

  initial begin
    #(200000 * 20);
    errors++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    for (int i = 0; i < 11; i++) sh[i] = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_nokick();
    t_table();
    t_boundary();
    t_fields();
    t_reserved();
    t_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule